// File: doc/BRIEF.md
# Serial Memory Target on a Two-Wire Bus

This block is the target side of a two-wire serial bus (I2C) in front of a small on-chip byte store. It runs entirely on the system clock: the bus clock and data lines are brought in through a synchronizer and watched for edges. It recognises the bus framing events and answers only when the device address matches. While it answers, it either takes in bytes or sends them out. The data line is never driven high. The block only asserts an enable that pulls the line low, and the pad or the bench forms the wired-AND.

A master selects the device with an address byte. The upper four bits of that byte are a fixed prefix. The next three bits must match the `strap` pins, so that up to eight such devices can share one bus. The last bit picks the direction. In a write transfer, the first data byte sets the internal byte pointer and each later byte is stored at the pointer. In a read transfer, bytes are streamed out from the pointer for as long as the master acknowledges. After every byte, in either direction, the pointer advances and wraps at the store size. The pointer keeps its value between transfers, so a write of the pointer, then a repeated START, then a read gives a random read.

The bus has no back-pressure on either side. Bytes move at the pace of the master's clock, and the store is always ready within one system cycle.

Top module: `i2cm_target`

## Requirements
- R1: A START is SDA falling while SCL is high. Out of reset, and until the first START, the block never asserts `sda_oe`, whatever is clocked on the bus.
- R2: A STOP is SDA rising while SCL is high. It ends any transfer, including one cut off in the middle of a byte, and releases SDA. The next START is then served normally.
- R3: A data bit is taken at the rising edge of SCL, most significant bit first. A byte written and then read back returns the same value.
- R4: The first byte after a START holds, from bit 7 down to bit 0: the prefix 1,0,1,0, then three select bits that must equal `strap[2:0]` (bit 3 compared with strap[2]), then the direction bit (1 = read, 0 = write). On a match, `sda_oe` is 1 throughout the ninth SCL clock.
- R5: If the prefix or the select bits differ, the ninth clock is not acknowledged. Every following byte is also left unacknowledged until the next START.
- R6: In a write, every data byte is acknowledged. The first data byte, taken modulo DEPTH, loads the pointer. Each later byte is stored at the pointer, and the pointer then steps by one, wrapping from DEPTH-1 to 0.
- R7: In a read, the byte at the pointer is sent MSB first, with `sda_oe`=1 for a 0 bit. SDA is released for the ninth clock. A low (ACK) there sends the next byte. The pointer steps by one (wrapping) per byte loaded and keeps its value across transfers.
- R8: After a read byte is not acknowledged, the block stays silent: a START is ignored and `sda_oe` stays 0 until a STOP.
- R9: `sda_oe` changes only while SCL is low, following a detected SCL falling edge, or when a START or STOP resets the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND result) |
| strap | input | 3 | Hardwired device select bits |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Several properties are checked on every cycle by the assertions:
- `sda_oe` moves only after an SCL fall or a START/STOP event.
- A STOP always returns the block to idle with SDA released.
- A START, unless the block is waiting for a STOP, reopens address reception.
- SDA stays released during the master's acknowledge slot and while the block waits after a refused byte.
- An address mismatch leaves the bus untouched.
- Every store write lands at the pointer.

Only the bench scenarios can show the transfer-level behaviour: that the address decode works for every strap and select combination, that stored data and pointer wrap-around read back correctly, that a cut-off byte is not stored, and that the pointer carries over from one transfer to the next.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MACK_END,
    ST_WAIT_STOP
  } ctl_st_e;
endpackage

// File: rtl/i2cm_bus_sync.sv
module i2cm_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_pipe, sda_pipe;
  logic          scl_d, sda_d, scl_lvl;

  // Synchronizer chain per line; depth chosen by parameter.
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_in;
          sda_pipe[g] <= sda_in;
        end else begin
          scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g - 1];
          sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_pipe[LAST];
  assign sda_lvl = sda_pipe[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2cm_store.sv
module i2cm_store
  import i2cm_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [BYTE_W-1:0] ptr_val,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_adv,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [BYTE_W-1:0] cells [DEPTH];
  logic [AW-1:0]     ptr;
  logic [AW-1:0]     ptr_next;

  assign ptr_next = (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
  assign rd_data  = cells[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_load) begin
      ptr <= AW'(ptr_val % DEPTH);
    end else if (wr_en || rd_adv) begin
      ptr <= ptr_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[ptr] <= wr_data;
    end
  end

  // R6: a stored byte lands at the pointer held when the write strobe fired
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells[$past(ptr)] == $past(wr_data));

  // R7: without a strobe the pointer keeps its value between transfers
  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_load || wr_en || rd_adv) |=> $stable(ptr));
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [SEL_W-1:0]  strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              ptr_load,
  output logic [BYTE_W-1:0] ptr_val,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_adv,
  output logic              sda_oe
);
  ctl_st_e           st;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              is_addr, rd_mode, have_ptr, mack_q;
  logic              addr_hit, data_end, load_tx;

  assign addr_hit = (rx_sh[7:4] == DEV_PREFIX) && (rx_sh[3:1] == strap);
  assign data_end = (st == ST_RX_END) && scl_fall && !is_addr;
  assign ptr_load = data_end && !have_ptr;
  assign wr_en    = data_end && have_ptr;
  assign ptr_val  = rx_sh;
  assign wr_data  = rx_sh;
  assign load_tx  = scl_fall && (((st == ST_ACK) && rd_mode) ||
                                 ((st == ST_MACK_END) && mack_q));
  assign rd_adv   = load_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      have_ptr <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_evt && st != ST_WAIT_STOP) begin
      st       <= ST_RX;
      is_addr  <= 1'b1;
      bit_cnt  <= '0;
      rd_mode  <= 1'b0;
      have_ptr <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      case (st)
        ST_RX: if (scl_rise) begin
          rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) st <= ST_RX_END;
        end
        ST_RX_END: if (scl_fall) begin
          if (is_addr) begin
            if (addr_hit) begin
              sda_oe  <= 1'b1;
              rd_mode <= rx_sh[0];
              is_addr <= 1'b0;
              st      <= ST_ACK;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            sda_oe   <= 1'b1;
            have_ptr <= 1'b1;
            st       <= ST_ACK;
          end
        end
        ST_ACK: if (scl_fall) begin
          bit_cnt <= '0;
          if (rd_mode) begin
            tx_sh  <= rd_data;
            sda_oe <= ~rd_data[BYTE_W-1];
            st     <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            st     <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            sda_oe <= 1'b0;
            st     <= ST_MACK;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
            sda_oe  <= ~tx_sh[BYTE_W-2];
          end
        end
        ST_MACK: if (scl_rise) begin
          mack_q <= ~sda_lvl;
          st     <= ST_MACK_END;
        end
        ST_MACK_END: if (scl_fall) begin
          if (mack_q) begin
            tx_sh   <= rd_data;
            sda_oe  <= ~rd_data[BYTE_W-1];
            bit_cnt <= '0;
            st      <= ST_TX;
          end else begin
            st <= ST_WAIT_STOP;
          end
        end
        default: ;
      endcase
    end
  end

  // R9: the data enable moves only after an SCL fall or a START/STOP
  a_r9_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  // R2: a STOP always returns to idle with SDA released
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st == ST_IDLE) && !sda_oe);

  // R1: a START reopens address reception
  a_r1_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !stop_evt && st != ST_WAIT_STOP) |=>
      (st == ST_RX) && is_addr && (bit_cnt == 3'd0) && !sda_oe);

  // R5: a mismatching address byte leaves the bus untouched
  a_r5_mismatch_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX_END && is_addr && scl_fall && rx_sh[3:1] != strap) |=>
      !sda_oe && (st == ST_IDLE));

  // R7: SDA is released during the master's acknowledge slot
  a_r7_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK || st == ST_MACK_END) |-> !sda_oe);

  // R8: silent after a refused read byte
  a_r8_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT_STOP) |-> !sda_oe);
endmodule

// File: rtl/i2cm_target.sv
module i2cm_target
  import i2cm_pkg::*;
#(
  parameter int         DEPTH       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  output logic       sda_oe
);
  logic              sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic              ptr_load, wr_en, rd_adv;
  logic [BYTE_W-1:0] ptr_val, wr_data, rd_data;

  i2cm_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cm_ctrl #(.DEV_PREFIX(DEV_PREFIX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .strap(strap), .rd_data(rd_data), .ptr_load(ptr_load),
    .ptr_val(ptr_val), .wr_en(wr_en), .wr_data(wr_data),
    .rd_adv(rd_adv), .sda_oe(sda_oe)
  );

  i2cm_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .wr_en(wr_en), .wr_data(wr_data), .rd_adv(rd_adv), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_i2cm_target.sv
module sim_i2cm_target;
  localparam int CLK_P = 10;
  localparam int Q     = 6;     // system cycles per quarter bus bit
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       sda_oe;
  logic       sda_bus;
  int         n_chk = 0, n_fail = 0, r9_viol = 0;
  bit         finished = 1'b0;
  logic       oe_prev = 1'b0;

  assign sda_bus = m_sda & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2cm_target #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .strap(strap), .sda_oe(sda_oe)
  );

  // R9 monitor: the target's enable may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && m_scl) r9_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = (a == 1'b0);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  function automatic logic [7:0] pat_a(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] pat_b(input int k);
    return 8'((k * 29 + 3) & 255);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    int ones;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: a matching address clocked without START gets no answer
    m_scl = 1'b0; wq();
    send_byte(8'hA0, ack);
    chk(!ack, "R1 no START", int'(ack), 0);
    bus_stop();

    // R4/R5: sweep every strap against every select value
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        send_byte({4'b1010, 3'(a), 1'b0}, ack);
        chk(ack == (a == s), "R4 select match", int'(ack), int'(a == s));
        if (a != s) begin
          send_byte(8'h5A, ack);
          chk(!ack, "R5 ignored after mismatch", int'(ack), 0);
        end
        bus_stop();
      end
    end

    strap = 3'd3;
    // R4: wrong prefix with matching select bits
    for (int p = 0; p < 16; p++) begin
      if (p != 10) begin
        bus_start();
        send_byte({4'(p), 3'd3, 1'b1}, ack);
        chk(!ack, "R4 prefix mismatch", int'(ack), 0);
        bus_stop();
      end
    end

    // R6: write four bytes from pointer 14, wrapping to 0 and 1
    bus_start();
    send_byte(8'hA6, ack); chk(ack, "R4 write address", int'(ack), 1);
    send_byte(8'd14, ack); chk(ack, "R6 pointer byte", int'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(pat_a(i), ack);
      chk(ack, "R6 data ack", int'(ack), 1);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R2 released after STOP", int'(sda_oe), 0);

    // R7: random read of the wrapped bytes
    bus_start(); send_byte(8'hA6, ack); send_byte(8'd14, ack);
    bus_start(); send_byte(8'hA7, ack); chk(ack, "R4 read address", int'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, v);
      chk(v == pat_a(i), "R6 wrap readback", int'(v), int'(pat_a(i)));
    end
    bus_stop();

    // R3: fill the store from 0, then stream 18 bytes back
    bus_start(); send_byte(8'hA6, ack); send_byte(8'd0, ack);
    for (int k = 0; k < DEPTH; k++) send_byte(pat_b(k), ack);
    bus_stop();
    bus_start(); send_byte(8'hA6, ack); send_byte(8'd0, ack);
    bus_start(); send_byte(8'hA7, ack);
    for (int k = 0; k < DEPTH + 2; k++) begin
      recv_byte(k != DEPTH + 1, v);
      chk(v == pat_b(k % DEPTH), "R3 R7 stream readback", int'(v), int'(pat_b(k % DEPTH)));
    end

    // R8: after the refused byte the target stays silent
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      logic b; get_bit(b); ones += int'(b);
    end
    chk(ones == 8, "R8 silent after NACK", ones, 8);
    bus_start();
    send_byte(8'hA7, ack);
    chk(!ack, "R8 START ignored", int'(ack), 0);
    bus_stop();

    // R2/R7: served again after STOP; pointer carried over (18 mod 16 = 2)
    bus_start(); send_byte(8'hA7, ack);
    chk(ack, "R2 served after STOP", int'(ack), 1);
    recv_byte(1'b0, v);
    chk(v == pat_b(2), "R7 pointer persists", int'(v), int'(pat_b(2)));
    bus_stop();

    // R2: STOP in the middle of a byte stores nothing
    bus_start(); send_byte(8'hA6, ack); send_byte(8'd5, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    chk(sda_oe == 1'b0, "R2 mid-byte STOP", int'(sda_oe), 0);
    bus_start(); send_byte(8'hA6, ack); send_byte(8'd5, ack);
    bus_start(); send_byte(8'hA7, ack);
    recv_byte(1'b0, v);
    chk(v == pat_b(5), "R2 cut byte not stored", int'(v), int'(pat_b(5)));
    bus_stop();

    chk(r9_viol == 0, "R9 enable moved with SCL high", r9_viol, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule